// File: doc/BRIEF.md
# Packed-Syllable Instruction Sequencer

The sequencer is the front end of a small stack machine. It reads 32-bit instruction words through a synchronous memory read port, where data returns one cycle after the request, and sorts each word into one of three formats. A word with bit 31 set carries a 31-bit literal. The sequencer turns that literal into a single push item whose value is the literal shifted left by one, with bit 0 cleared. A word whose top two bits are `00` packs five 6-bit syllables. The sequencer hands these to the execution unit one at a time, over a valid/ready handshake, starting with the most significant syllable. A word whose top two bits are `01` has no defined operation. It raises an illegal-instruction flag and freezes the sequencer until reset.

Two counters are visible at the ports. The program counter holds a byte address that advances by four at every fetch. The syllable counter tells which slot of the current word comes next. Both counters always point past the item currently on offer. The execution unit can redirect the flow at any time. A redirect loads the program counter with the target, clears the syllable counter and discards the rest of the current word, including any word still in flight from memory.

Top module: `pks_sequencer`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, pc_o equals RESET_PC (default 0), sc_o is 0, issue_valid_o and illegal_o are low, and mem_req_o is high with mem_addr_o equal to RESET_PC.
- R2: A fetch request lasts exactly one cycle and addresses pc_o. In the following cycle pc_o equals the requested address plus 4, and that value stays on pc_o while the items of the word are offered.
- R3: A fetched word with bit 31 = 1 produces exactly one item with issue_imm_o = 1 and issue_value_o = {word[30:0], 1'b0}.
- R4: A fetched word with bits 31:30 = 00 produces five items with issue_imm_o = 0, in this order: issue_syl_o = word[29:24], word[23:18], word[17:12], word[11:6], word[5:0].
- R5: While an item is offered, sc_o is 0 for a push item. For the k-th syllable (k = 1..5) it is k mod 5, so the third syllable shows 3 and the fifth shows 0.
- R6: While issue_valid_o is high and issue_ready_i is low, with no redirect, the offered item (issue_imm_o, issue_syl_o, issue_value_o) stays unchanged in the next cycle.
- R7: In the cycle after the last item of a word is accepted, a fetch request is issued at the address following that word.
- R8: A redirect that is not ignored sets pc_o to redirect_target_i and sc_o to 0 in the next cycle, with a fetch request at the target. All remaining syllables and any word in flight are dropped, so the next item offered comes from the target word.
- R9: While redirect_valid_i is high (and the sequencer is not halted), issue_valid_o is low, so no item is accepted in a redirect cycle.
- R10: A fetched word with bits 31:30 = 01 sets illegal_o. It then stays high until reset, no fetch or item is issued, redirects are ignored, and pc_o holds the address after that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Instruction read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| issue_valid_o | output | 1 | An item is on offer |
| issue_ready_i | input | 1 | Execution unit accepts the offered item |
| issue_imm_o | output | 1 | 1: push item, 0: syllable item |
| issue_syl_o | output | SYL_W | Syllable code (0 for push items) |
| issue_value_o | output | 32 | Push value (0 for syllable items) |
| redirect_valid_i | input | 1 | Load a new program counter |
| redirect_target_i | input | ADDR_W | Redirect target address |
| pc_o | output | ADDR_W | Program counter |
| sc_o | output | SLOT_W | Syllable counter |
| illegal_o | output | 1 | Reserved format fetched; sequencer halted |

## Verification
The hard case is a redirect that arrives in the same cycle as other activity. It may coincide with a handshake that would otherwise accept a syllable, or with the cycle in which a fetched word returns from memory. The bench asserts redirects at random cycles while the ready signal toggles at random, so both collisions occur many times. Each collision is judged by the rules that no item is taken in the redirect cycle and that the very next item comes from the target word. A reference cursor in the bench follows the word address and slot to decide this.

// File: rtl/pks_pkg.sv
package pks_pkg;
  typedef enum logic [1:0] {
    FMT_SYL = 2'd0,
    FMT_RSV = 2'd1,
    FMT_IMM = 2'd2
  } fmt_e;

  typedef enum logic [2:0] {
    ST_REQ  = 3'd0,
    ST_RESP = 3'd1,
    ST_IMM  = 3'd2,
    ST_SYL  = 3'd3,
    ST_ILL  = 3'd4
  } state_e;
endpackage

// File: rtl/pks_classify.sv
module pks_classify
  import pks_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output fmt_e              fmt_o,
  output logic [WORD_W-1:0] imm_o
);
  always_comb begin
    if (word_i[WORD_W-1])      fmt_o = FMT_IMM;
    else if (word_i[WORD_W-2]) fmt_o = FMT_RSV;
    else                       fmt_o = FMT_SYL;
  end

  // literal lands one bit up, LSB zero
  assign imm_o = {word_i[WORD_W-2:0], 1'b0};
endmodule

// File: rtl/pks_pc.sv
module pks_pc #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          STEP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= ADDR_W'(RESET_PC);
    else if (load_i)    pc_q <= target_i;
    else if (advance_i) pc_q <= pc_q + ADDR_W'(STEP);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pks_unpack.sv
module pks_unpack #(
  parameter int SYL_W = 6,
  parameter int SYL_N = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SYL_N*SYL_W-1:0]   body_i,
  input  logic                     clear_i,
  input  logic                     step_i,
  output logic [SYL_W-1:0]         syl_o,
  output logic [$clog2(SYL_N)-1:0] sc_o,
  output logic                     last_o
);
  localparam int BODY_W = SYL_N * SYL_W;
  localparam int SLOT_W = $clog2(SYL_N);

  logic [SYL_W-1:0]  syl_arr [SYL_N];
  logic [SLOT_W-1:0] slot_q;

  // slot 0 sits in the most significant field
  for (genvar g = 0; g < SYL_N; g++) begin : g_field
    assign syl_arr[g] = body_i[BODY_W-1-g*SYL_W -: SYL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (clear_i) slot_q <= '0;
    else if (step_i)  slot_q <= last_o ? '0 : slot_q + 1'b1;
  end

  assign last_o = (slot_q == SLOT_W'(SYL_N - 1));
  assign syl_o  = syl_arr[slot_q];
  // counter names the slot after the one on offer, wrapping to 0
  assign sc_o   = last_o ? '0 : slot_q + 1'b1;

  // R5
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SLOT_W'(SYL_N));
endmodule

// File: rtl/pks_sequencer.sv
module pks_sequencer
  import pks_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          SYL_W    = 6,
  parameter int          SYL_N    = 5,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         WORD_W   = 2 + SYL_N * SYL_W,
  localparam int         SLOT_W   = $clog2(SYL_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  output logic              issue_imm_o,
  output logic [SYL_W-1:0]  issue_syl_o,
  output logic [WORD_W-1:0] issue_value_o,
  input  logic              redirect_valid_i,
  input  logic [ADDR_W-1:0] redirect_target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [SLOT_W-1:0] sc_o,
  output logic              illegal_o
);
  localparam int BODY_W = SYL_N * SYL_W;
  localparam int STEP   = WORD_W / 8;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] payload_q;
  fmt_e              rsp_fmt;
  logic [WORD_W-1:0] rsp_imm;
  logic              redir, accept;
  logic [SYL_W-1:0]  unp_syl;
  logic [SLOT_W-1:0] unp_sc;
  logic              unp_last;
  logic [ADDR_W-1:0] pc;

  pks_classify #(.WORD_W(WORD_W)) i_classify (
    .word_i (mem_rdata_i),
    .fmt_o  (rsp_fmt),
    .imm_o  (rsp_imm)
  );

  assign redir  = redirect_valid_i && (state_q != ST_ILL);
  assign accept = issue_valid_o && issue_ready_i;

  always_comb begin
    state_d = state_q;
    if (redir) begin
      state_d = ST_REQ;
    end else begin
      unique case (state_q)
        ST_REQ:  state_d = ST_RESP;
        ST_RESP: begin
          unique case (rsp_fmt)
            FMT_IMM: state_d = ST_IMM;
            FMT_RSV: state_d = ST_ILL;
            default: state_d = ST_SYL;
          endcase
        end
        ST_IMM:  if (accept) state_d = ST_REQ;
        ST_SYL:  if (accept && unp_last) state_d = ST_REQ;
        default: state_d = ST_ILL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_REQ;
    else         state_q <= state_d;
  end

  // one register carries either the push value or the packed word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      payload_q <= '0;
    else if (state_q == ST_RESP && !redir)
      payload_q <= (rsp_fmt == FMT_IMM) ? rsp_imm : mem_rdata_i;
  end

  pks_pc #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC),
    .STEP     (STEP)
  ) i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (state_q == ST_REQ && !redir),
    .load_i    (redir),
    .target_i  (redirect_target_i),
    .pc_o      (pc)
  );

  pks_unpack #(
    .SYL_W (SYL_W),
    .SYL_N (SYL_N)
  ) i_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .body_i  (payload_q[BODY_W-1:0]),
    .clear_i (redir || state_q == ST_RESP),
    .step_i  (state_q == ST_SYL && accept),
    .syl_o   (unp_syl),
    .sc_o    (unp_sc),
    .last_o  (unp_last)
  );

  assign mem_req_o     = (state_q == ST_REQ);
  assign mem_addr_o    = pc;
  assign pc_o          = pc;
  assign illegal_o     = (state_q == ST_ILL);
  assign issue_valid_o = (state_q == ST_IMM || state_q == ST_SYL) && !redirect_valid_i;
  assign issue_imm_o   = (state_q == ST_IMM);
  assign issue_syl_o   = (state_q == ST_SYL) ? unp_syl : '0;
  assign issue_value_o = (state_q == ST_IMM) ? payload_q : '0;
  assign sc_o          = (state_q == ST_SYL) ? unp_sc : '0;

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !redirect_valid_i) |=> (pc_o == $past(mem_addr_o) + ADDR_W'(STEP)) && !mem_req_o);

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_ready_i) |=>
      $stable(issue_imm_o) && $stable(issue_syl_o) && $stable(issue_value_o));

  // R8
  redir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_valid_i && !illegal_o) |=>
      (pc_o == $past(redirect_target_i)) && (sc_o == '0) && mem_req_o);

  // R9
  redir_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_valid_i && !illegal_o) |-> !issue_valid_o);

  // R10
  illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o && $stable(pc_o));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && !issue_valid_o);
endmodule

// File: tb/test_pks_sequencer.sv
module test_pks_sequencer;
  localparam int AW = 32;
  localparam int SW = 6;
  localparam int SN = 5;
  localparam int WW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [WW-1:0] mem_rdata_i;
  logic          issue_valid_o, issue_ready_i, issue_imm_o;
  logic [SW-1:0] issue_syl_o;
  logic [WW-1:0] issue_value_o;
  logic          redirect_valid_i;
  logic [AW-1:0] redirect_target_i;
  logic [AW-1:0] pc_o;
  logic [2:0]    sc_o;
  logic          illegal_o;

  always #10 clk_i = ~clk_i;

  pks_sequencer i_pks_sequencer (
    .clk_i, .rst_ni, .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .issue_valid_o, .issue_ready_i, .issue_imm_o, .issue_syl_o, .issue_value_o,
    .redirect_valid_i, .redirect_target_i, .pc_o, .sc_o, .illegal_o
  );

  logic [31:0] mem [64];
  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[7:2]];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] syl_of(input logic [31:0] w, input int s);
    return w[29-6*s -: 6];
  endfunction

  function automatic logic [2:0] sc_of(input logic [31:0] w, input int s);
    if (w[31]) return 3'd0;
    return 3'((s + 1) % SN);
  endfunction

  initial begin
    logic [31:0] cur;
    int          slot;
    bit          r8_pend, stall_prev;
    logic [31:0] r8_tgt, prev_val;
    logic [5:0]  prev_syl;
    logic        prev_imm;
    int          accepts;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (w[31:30] == 2'b01) w[31:30] = 2'b00;
      mem[i] = w;
    end
    mem[0] = 32'hC040_4040;
    mem[1] = {2'b00, 6'h21, 6'h0A, 6'h3F, 6'h01, 6'h18};
    rst_ni = 1'b0; issue_ready_i = 1'b0; redirect_valid_i = 1'b0; redirect_target_i = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(pc_o == 0, "R1 pc", pc_o, 0);
    chk(sc_o == 0, "R1 sc", 32'(sc_o), 0);
    chk(!issue_valid_o && !illegal_o, "R1 flags", {issue_valid_o, illegal_o}, 0);
    chk(mem_req_o && mem_addr_o == 0, "R1 req", mem_addr_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk(mem_req_o && mem_addr_o == 0, "R1 first fetch", mem_addr_o, 0);
    cur = 0; slot = 0; r8_pend = 0; stall_prev = 0; accepts = 0;
    r8_tgt = 0; prev_val = 0; prev_syl = 0; prev_imm = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [31:0] w;
      @(negedge clk_i);
      if (cyc < 40) begin
        issue_ready_i = 1'b1; redirect_valid_i = 1'b0;
      end else begin
        issue_ready_i = ($urandom % 4) != 0;
        redirect_valid_i = ($urandom % 19) == 0;
        redirect_target_i = 32'($urandom % 64) << 2;
      end
      #1;
      if (r8_pend) begin
        chk(pc_o == r8_tgt && sc_o == 0 && mem_req_o, "R8 redirect load", pc_o, r8_tgt);
        r8_pend = 0;
      end
      if (stall_prev && !redirect_valid_i)
        chk(issue_valid_o && issue_imm_o == prev_imm && issue_syl_o == prev_syl &&
            issue_value_o == prev_val, "R6 hold", {26'd0, issue_syl_o}, {26'd0, prev_syl});
      stall_prev = 0;
      if (mem_req_o && !redirect_valid_i)
        chk(mem_addr_o == cur, "R7 fetch address", mem_addr_o, cur);
      if (redirect_valid_i) begin
        chk(!issue_valid_o, "R9 valid masked", {31'd0, issue_valid_o}, 0);
        cur = redirect_target_i; slot = 0;
        r8_pend = 1; r8_tgt = redirect_target_i;
      end else if (issue_valid_o) begin
        w = mem[cur[7:2]];
        chk(pc_o == cur + 4, "R2 pc ahead", pc_o, cur + 4);
        chk(sc_o == sc_of(w, slot), "R5 sc", 32'(sc_o), 32'(sc_of(w, slot)));
        if (w[31]) begin
          chk(issue_imm_o, "R3 kind", {31'd0, issue_imm_o}, 1);
          chk(issue_value_o == {w[30:0], 1'b0}, "R3 value", issue_value_o, {w[30:0], 1'b0});
        end else begin
          chk(!issue_imm_o, "R4 kind", {31'd0, issue_imm_o}, 0);
          chk(issue_syl_o == syl_of(w, slot), "R4 syllable", 32'(issue_syl_o), 32'(syl_of(w, slot)));
        end
        if (issue_ready_i) begin
          accepts++;
          if (w[31] || slot == SN - 1) begin cur = cur + 4; slot = 0; end
          else slot++;
        end else begin
          stall_prev = 1; prev_imm = issue_imm_o; prev_syl = issue_syl_o; prev_val = issue_value_o;
        end
      end
    end
    chk(accepts > 500, "R2 progress", 32'(accepts), 500);
    // reserved format
    @(negedge clk_i);
    mem[60] = 32'h4000_0000;
    issue_ready_i = 1'b1; redirect_valid_i = 1'b1; redirect_target_i = 32'hF0;
    @(negedge clk_i); redirect_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    #1;
    chk(illegal_o, "R10 flag", {31'd0, illegal_o}, 1);
    chk(!mem_req_o && !issue_valid_o, "R10 quiet", {mem_req_o, issue_valid_o}, 0);
    chk(pc_o == 32'hF4, "R10 pc", pc_o, 32'hF4);
    @(negedge clk_i); redirect_valid_i = 1'b1; redirect_target_i = 32'h0;
    @(negedge clk_i); redirect_valid_i = 1'b0;
    #1;
    chk(illegal_o && pc_o == 32'hF4 && !mem_req_o, "R10 redirect ignored", pc_o, 32'hF4);
    rst_ni = 1'b0;
    #1;
    chk(!illegal_o && pc_o == 0, "R1 reset clears halt", pc_o, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule